// File: doc/BRIEF.md
# Peripheral Slot ROM Decoder

This block sits on the system bus of an 8-bit machine and decides, for each access into the peripheral firmware window, which source answers it: the on-board firmware ROM or one of the plug-in cards. The window has two parts. The first is seven 256-byte card pages at $C100–$C7FF, one per slot, where the slot number is taken from the address. The second is a 2 KB expansion area at $C800–$CFFF, shared by all cards.

Three sticky flags steer the choice. The internal-firmware flag hands the whole window to the ROM. The slot-3 card flag decides whether page $C3xx belongs to the card or to the ROM. The expansion-claim flag is set when the ROM takes over page $C3xx, and it gives the ROM the expansion area too. The block also remembers which card page was touched last. That card owns the expansion area until $CFFF is touched, which releases the claim.

Software sets the flags by writing to soft-switch addresses and reads two of them back as status bytes. A read from a card page or expansion slot with no card fitted is flagged so that the data mux returns $FF. The block holds no ROM contents and no card logic. Its outputs are selects and an offset that are combinational in the current access, plus flags that update at the clock edge that ends a valid access.

Top module: `slot_rom_decoder`

## Requirements
- R1: After the asynchronous reset, the internal-firmware flag, the slot-3 card flag and the expansion-claim flag are all 0, and the last-slot register is 0.
- R2: While the internal-firmware flag is 1, a read in $C100–$C7FF asserts the ROM select and no page select. A write there asserts nothing and does not change the last-slot register.
- R3: With the internal-firmware flag at 0, an access to $Cs00–$CsFF (s = address bits [10:8], 1..7, not the slot-3 ROM case) asserts page_sel_o bit s and puts address bits [7:0] on the offset. It also stores s as the last slot.
- R4: With both the internal-firmware flag and the slot-3 card flag at 0, an access to $C300–$C3FF asserts the ROM select on a read and nothing on a write. It sets the expansion-claim flag and stores 3 as the last slot.
- R5: An access in $C800–$CFFE asserts the ROM select on a read, and nothing on a write, while either the internal-firmware or the expansion-claim flag is 1. Otherwise it asserts exp_sel_o bit L, where L is the last slot, with address bits [10:0] on the offset. When L is 0 there is no select.
- R6: Any valid access to $CFFF clears the expansion-claim flag. A read there asserts the ROM select.
- R7: Writes to $C006/$C007 load address bit 0 into the internal-firmware flag. Writes to $C00A/$C00B load it into the slot-3 card flag. Reads of these addresses change nothing.
- R8: A read of $C015 returns the internal-firmware flag, and a read of $C017 returns the slot-3 card flag. In both cases stat_valid_o is 1 and stat_data_o carries the flag in bit 7, with bits 6:0 at 0. Writes there produce no status.
- R9: A read that reaches a card page or expansion select for a slot whose populated_i bit is 0 asserts ff_o. Slot 0 always counts as empty, so an expansion read with last slot 0 asserts ff_o. Writes never assert ff_o.
- R10: When valid_i is 0, or the address lies outside the decoded set, all selects, ff_o and stat_valid_o are 0. When valid_i is 0, no flag and no last-slot state changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Bus access in progress this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 16 | Bus address |
| populated_i | input | 8 | Card fitted in slot s (bit 0 ignored) |
| rom_sel_o | output | 1 | Firmware ROM drives the read |
| page_sel_o | output | 8 | One-hot card page select |
| exp_sel_o | output | 8 | One-hot card expansion select |
| offset_o | output | 11 | Offset passed to the selected card |
| ff_o | output | 1 | Substitute $FF for read data |
| stat_valid_o | output | 1 | Status byte is driven |
| stat_data_o | output | 8 | Status byte |
| intcx_o | output | 1 | Internal-firmware flag |
| slotc3_o | output | 1 | Slot-3 card flag |
| intc8_o | output | 1 | Expansion-claim flag |

## Verification
A wrong flag or last-slot value stays hidden until an access depends on it. A stale last slot shows up only at the next expansion access, which goes to the wrong card or asserts ff_o when it should not. A claim flag that fails to clear makes every later $C800–$CFFE read go to the ROM until the next $CFFF access. The reference model therefore follows the flags and the last slot cycle by cycle and compares every output on every access. Directed sequences set up the ownership hand-offs, and a long mixed run then reaches order-dependent states.

// File: rtl/slot_dec_pkg.sv
package slot_dec_pkg;
  typedef enum logic [2:0] {
    REG_NONE,
    REG_PAGE,
    REG_EXP,
    REG_C8OFF,
    REG_SW_CX,
    REG_SW_C3,
    REG_ST_CX,
    REG_ST_C3
  } region_e;

  localparam logic [15:0] ADR_SW_CX = 16'hC006;
  localparam logic [15:0] ADR_SW_C3 = 16'hC00A;
  localparam logic [15:0] ADR_ST_CX = 16'hC015;
  localparam logic [15:0] ADR_ST_C3 = 16'hC017;
  localparam logic [15:0] ADR_C8OFF = 16'hCFFF;
  localparam logic [4:0]  PAGE_HI   = 5'b11000;
  localparam logic [4:0]  EXP_HI    = 5'b11001;
endpackage

// File: rtl/slot_region_decode.sv
module slot_region_decode
  import slot_dec_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int SLOT_W = 3
) (
  input  logic [ADDR_W-1:0] addr_i,
  output region_e           region_o,
  output logic [SLOT_W-1:0] slot_o
);
  always_comb begin
    slot_o   = addr_i[8 +: SLOT_W];
    region_o = REG_NONE;
    if (addr_i[15:11] == PAGE_HI && addr_i[10:8] != 3'd0)
      region_o = REG_PAGE;
    else if (addr_i == ADR_C8OFF)
      region_o = REG_C8OFF;
    else if (addr_i[15:11] == EXP_HI)
      region_o = REG_EXP;
    else if (addr_i[15:1] == ADR_SW_CX[15:1])
      region_o = REG_SW_CX;
    else if (addr_i[15:1] == ADR_SW_C3[15:1])
      region_o = REG_SW_C3;
    else if (addr_i == ADR_ST_CX)
      region_o = REG_ST_CX;
    else if (addr_i == ADR_ST_C3)
      region_o = REG_ST_C3;
  end
endmodule

// File: rtl/slot_flag_regs.sv
module slot_flag_regs
  import slot_dec_pkg::*;
#(
  parameter int SLOT_W  = 3,
  parameter int C3_SLOT = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              we_i,
  input  region_e           region_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic              addr0_i,
  output logic              intcx_o,
  output logic              slotc3_o,
  output logic              intc8_o,
  output logic [SLOT_W-1:0] last_slot_o
);
  localparam logic [SLOT_W-1:0] C3_IDX = SLOT_W'(C3_SLOT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      intcx_o     <= 1'b0;
      slotc3_o    <= 1'b0;
      intc8_o     <= 1'b0;
      last_slot_o <= '0;
    end else if (valid_i) begin
      unique case (region_i)
        REG_SW_CX: if (we_i) intcx_o  <= addr0_i;
        REG_SW_C3: if (we_i) slotc3_o <= addr0_i;
        REG_PAGE: begin
          if (!intcx_o) begin
            last_slot_o <= slot_i;
            if (slot_i == C3_IDX && !slotc3_o) intc8_o <= 1'b1;
          end
        end
        REG_C8OFF: intc8_o <= 1'b0;
        default: ;
      endcase
    end
  end

  // R6
  c8_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && region_i == REG_C8OFF |=> !intc8_o);

  // R4
  c8_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && region_i == REG_PAGE && !intcx_o && slot_i == C3_IDX && !slotc3_o
    |=> intc8_o && last_slot_o == C3_IDX);

  // R7
  cx_switch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && we_i && region_i == REG_SW_CX |=> intcx_o == $past(addr0_i));

  // R10
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(intcx_o) && $stable(slotc3_o) && $stable(intc8_o)
                 && $stable(last_slot_o));

  // R2
  cx_keeps_slot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && region_i == REG_PAGE && intcx_o |=> $stable(last_slot_o));
endmodule

// File: rtl/slot_route.sv
module slot_route
  import slot_dec_pkg::*;
#(
  parameter int SLOT_W  = 3,
  parameter int OFF_W   = 11,
  parameter int C3_SLOT = 3,
  localparam int NSLOT  = 1 << SLOT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              we_i,
  input  region_e           region_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic [OFF_W-1:0]  addr_lo_i,
  input  logic [NSLOT-1:0]  populated_i,
  input  logic              intcx_i,
  input  logic              slotc3_i,
  input  logic              intc8_i,
  input  logic [SLOT_W-1:0] last_slot_i,
  output logic              rom_sel_o,
  output logic [NSLOT-1:0]  page_sel_o,
  output logic [NSLOT-1:0]  exp_sel_o,
  output logic [OFF_W-1:0]  offset_o,
  output logic              ff_o,
  output logic              stat_valid_o,
  output logic [7:0]        stat_data_o
);
  localparam logic [SLOT_W-1:0] C3_IDX = SLOT_W'(C3_SLOT);

  logic [NSLOT-1:0] fitted;
  logic [NSLOT-1:0] slot_dec, last_dec;

  assign fitted = populated_i & ~NSLOT'(1);

  genvar g;
  generate
    for (g = 0; g < NSLOT; g++) begin : g_dec
      assign slot_dec[g] = (slot_i == SLOT_W'(g));
      assign last_dec[g] = (last_slot_i == SLOT_W'(g)) && (g != 0);
    end
  endgenerate

  always_comb begin
    rom_sel_o    = 1'b0;
    page_sel_o   = '0;
    exp_sel_o    = '0;
    offset_o     = '0;
    ff_o         = 1'b0;
    stat_valid_o = 1'b0;
    stat_data_o  = '0;
    if (valid_i) begin
      unique case (region_i)
        REG_PAGE: begin
          if (intcx_i || (slot_i == C3_IDX && !slotc3_i)) begin
            rom_sel_o = !we_i;
          end else begin
            page_sel_o = slot_dec;
            offset_o   = {{(OFF_W-8){1'b0}}, addr_lo_i[7:0]};
            ff_o       = !we_i && !fitted[slot_i];
          end
        end
        REG_EXP: begin
          if (intcx_i || intc8_i) begin
            rom_sel_o = !we_i;
          end else begin
            exp_sel_o = last_dec;
            if (|last_dec) offset_o = addr_lo_i;
            ff_o = !we_i && !fitted[last_slot_i];
          end
        end
        REG_C8OFF: rom_sel_o = !we_i;
        REG_ST_CX: begin
          stat_valid_o = !we_i;
          stat_data_o  = {intcx_i && !we_i, 7'b0};
        end
        REG_ST_C3: begin
          stat_valid_o = !we_i;
          stat_data_o  = {slotc3_i && !we_i, 7'b0};
        end
        default: ;
      endcase
    end
  end

  // R3
  page_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(page_sel_o) && $onehot0(exp_sel_o));

  // R2
  cx_page_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && region_i == REG_PAGE && intcx_i |-> page_sel_o == '0);

  // R9
  wr_no_ff_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |-> !ff_o && !rom_sel_o && !stat_valid_o);

  // R10
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> !rom_sel_o && page_sel_o == '0 && exp_sel_o == '0 && !ff_o);
endmodule

// File: rtl/slot_rom_decoder.sv
module slot_rom_decoder
  import slot_dec_pkg::*;
#(
  parameter int SLOT_W  = 3,
  parameter int OFF_W   = 11,
  parameter int C3_SLOT = 3,
  localparam int NSLOT  = 1 << SLOT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             we_i,
  input  logic [15:0]      addr_i,
  input  logic [NSLOT-1:0] populated_i,
  output logic             rom_sel_o,
  output logic [NSLOT-1:0] page_sel_o,
  output logic [NSLOT-1:0] exp_sel_o,
  output logic [OFF_W-1:0] offset_o,
  output logic             ff_o,
  output logic             stat_valid_o,
  output logic [7:0]       stat_data_o,
  output logic             intcx_o,
  output logic             slotc3_o,
  output logic             intc8_o
);
  region_e           region;
  logic [SLOT_W-1:0] slot, last_slot;

  slot_region_decode #(.ADDR_W(16), .SLOT_W(SLOT_W)) u_dec (
    .addr_i   (addr_i),
    .region_o (region),
    .slot_o   (slot)
  );

  slot_flag_regs #(.SLOT_W(SLOT_W), .C3_SLOT(C3_SLOT)) u_flags (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .valid_i     (valid_i),
    .we_i        (we_i),
    .region_i    (region),
    .slot_i      (slot),
    .addr0_i     (addr_i[0]),
    .intcx_o     (intcx_o),
    .slotc3_o    (slotc3_o),
    .intc8_o     (intc8_o),
    .last_slot_o (last_slot)
  );

  slot_route #(.SLOT_W(SLOT_W), .OFF_W(OFF_W), .C3_SLOT(C3_SLOT)) u_route (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .valid_i      (valid_i),
    .we_i         (we_i),
    .region_i     (region),
    .slot_i       (slot),
    .addr_lo_i    (addr_i[OFF_W-1:0]),
    .populated_i  (populated_i),
    .intcx_i      (intcx_o),
    .slotc3_i     (slotc3_o),
    .intc8_i      (intc8_o),
    .last_slot_i  (last_slot),
    .rom_sel_o    (rom_sel_o),
    .page_sel_o   (page_sel_o),
    .exp_sel_o    (exp_sel_o),
    .offset_o     (offset_o),
    .ff_o         (ff_o),
    .stat_valid_o (stat_valid_o),
    .stat_data_o  (stat_data_o)
  );
endmodule

// File: tb/slot_rom_decoder_test.sv
module slot_rom_decoder_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic        we = 1'b0;
  logic [15:0] addr = 16'h0000;
  logic [7:0]  pop = 8'hFE;
  logic        rom_sel, ff, sv, cx, c3, c8;
  logic [7:0]  psel, esel, sd;
  logic [10:0] off;

  int checks = 0;
  int fails  = 0;

  // reference state
  bit m_cx, m_c3, m_c8;
  int m_last;

  // expected outputs
  bit       e_rom, e_ff, e_sv;
  logic [7:0]  e_page, e_exp, e_sd;
  logic [10:0] e_off;
  string    e_tag;

  always #4 clk = ~clk;

  slot_rom_decoder uut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .we_i(we), .addr_i(addr),
    .populated_i(pop), .rom_sel_o(rom_sel), .page_sel_o(psel), .exp_sel_o(esel),
    .offset_o(off), .ff_o(ff), .stat_valid_o(sv), .stat_data_o(sd),
    .intcx_o(cx), .slotc3_o(c3), .intc8_o(c8)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h (addr %h we %0d)",
               tag, what, act, exp, addr, we);
    end
  endtask

  function automatic bit fitted(int s);
    return (s != 0) && pop[s];
  endfunction

  task automatic model_eval(input bit v, input bit w, input int a);
    e_rom = 0; e_ff = 0; e_sv = 0; e_page = 0; e_exp = 0; e_sd = 0; e_off = 0;
    e_tag = "R10";
    if (!v) return;
    if (a >= 'hC100 && a <= 'hC7FF) begin
      int s = (a >> 8) & 7;
      if (m_cx) begin e_tag = "R2"; e_rom = !w; end
      else if (s == 3 && !m_c3) begin e_tag = "R4"; e_rom = !w; end
      else begin
        e_tag = "R3";
        e_page = 8'(1) << s;
        e_off = 11'(a & 'hFF);
        if (!w && !fitted(s)) begin e_ff = 1; e_tag = "R9"; end
      end
    end else if (a >= 'hC800 && a <= 'hCFFE) begin
      e_tag = "R5";
      if (m_cx || m_c8) e_rom = !w;
      else begin
        if (m_last != 0) begin
          e_exp = 8'(1) << m_last;
          e_off = 11'(a & 'h7FF);
        end
        if (!w && !fitted(m_last)) begin e_ff = 1; e_tag = "R9"; end
      end
    end else if (a == 'hCFFF) begin
      e_tag = "R6"; e_rom = !w;
    end else if (a == 'hC015 || a == 'hC017) begin
      e_tag = "R8";
      if (!w) begin
        e_sv = 1;
        e_sd = {((a == 'hC015) ? m_cx : m_c3), 7'b0};
      end
    end else if (a >= 'hC006 && a <= 'hC007) e_tag = "R7";
    else if (a >= 'hC00A && a <= 'hC00B) e_tag = "R7";
  endtask

  task automatic model_update(input bit v, input bit w, input int a);
    if (!v) return;
    if (w && (a == 'hC006 || a == 'hC007)) m_cx = a[0];
    else if (w && (a == 'hC00A || a == 'hC00B)) m_c3 = a[0];
    else if (a >= 'hC100 && a <= 'hC7FF) begin
      if (!m_cx) begin
        m_last = (a >> 8) & 7;
        if (m_last == 3 && !m_c3) m_c8 = 1;
      end
    end else if (a == 'hCFFF) m_c8 = 0;
  endtask

  task automatic step(input bit v, input bit w, input int a);
    @(negedge clk);
    valid = v; we = w; addr = 16'(a);
    #3;
    model_eval(v, w, a);
    chk(rom_sel == e_rom, e_tag, "rom_sel", int'(rom_sel), int'(e_rom));
    chk(psel == e_page, e_tag, "page_sel", int'(psel), int'(e_page));
    chk(esel == e_exp, e_tag, "exp_sel", int'(esel), int'(e_exp));
    chk(off == e_off, e_tag, "offset", int'(off), int'(e_off));
    chk(ff == e_ff, "R9", "ff", int'(ff), int'(e_ff));
    chk(sv == e_sv && sd == e_sd, "R8", "status", int'({sv, sd}), int'({e_sv, e_sd}));
    chk(cx == m_cx, "R7", "intcx", int'(cx), int'(m_cx));
    chk(c3 == m_c3, "R7", "slotc3", int'(c3), int'(m_c3));
    chk(c8 == m_c8, "R4", "intc8", int'(c8), int'(m_c8));
    @(posedge clk);
    model_update(v, w, a);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int pool[16] = '{'hC006, 'hC007, 'hC00A, 'hC00B, 'hC015, 'hC017, 'hC100,
                     'hC2A5, 'hC300, 'hC3FF, 'hC455, 'hC7FF, 'hC800, 'hCABC,
                     'hCFFE, 'hCFFF};
    m_cx = 0; m_c3 = 0; m_c8 = 0; m_last = 0;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk(cx == 0 && c3 == 0 && c8 == 0, "R1", "flags in reset", int'({cx, c3, c8}), 0);
    rst_n = 1'b1;
    // R1: last slot 0 -> expansion read has no select, substitutes FF
    step(1, 0, 'hC900);
    step(1, 0, 'hC015);
    step(1, 0, 'hC017);
    // R3 card pages, R9 empty slot 0 bit ignored
    pop = 8'b1010_1110;
    step(1, 0, 'hC112);
    step(1, 1, 'hC2FE);
    step(1, 0, 'hC401);  // R9 slot 4 empty
    step(1, 0, 'hC5AA);
    step(1, 0, 'hCC34);  // R5 expansion to slot 5
    step(1, 1, 'hC800);
    step(1, 0, 'hC7FF);
    step(1, 0, 'hC801);  // R5 slot 7
    // R4 slot-3 ROM path
    step(1, 1, 'hC333);
    step(1, 0, 'hCFFE);  // R5 claimed by ROM
    step(1, 1, 'hCFFE);
    step(1, 1, 'hCFFF);  // R6 clear on write
    step(1, 0, 'hC805);  // R5 goes to slot 3
    step(1, 0, 'hC3F0);
    step(1, 0, 'hCFFF);  // R6 read
    // R7 slot-3 card flag
    step(1, 0, 'hC00B);  // read: no effect
    step(1, 1, 'hC00B);
    step(1, 0, 'hC017);
    step(1, 0, 'hC300);  // R3 slot-3 card page now
    step(1, 0, 'hCABC);
    step(1, 1, 'hC00A);
    // R7 internal firmware flag, R2
    step(1, 1, 'hC007);
    step(1, 0, 'hC015);
    step(1, 1, 'hC015);  // R8 write: no status
    step(1, 0, 'hC200);
    step(1, 1, 'hC600);  // R2 write ignored, last slot kept
    step(1, 0, 'hC900);
    step(1, 1, 'hC006);
    step(1, 0, 'hC900);  // R5 still last slot from before
    // R10 valid low
    step(0, 1, 'hC007);
    step(0, 0, 'hC300);
    step(0, 0, 'hC500);
    step(1, 0, 'hD000);
    step(1, 0, 'hC015);
    // mixed run
    for (int i = 0; i < 4000; i++) begin
      if (i % 97 == 0) pop = 8'($urandom);
      step(($urandom % 8) != 0, $urandom % 2, pool[$urandom % 16] ^ (($urandom % 2) ? 'h0 : 'h10) & 'hFFFF);
    end
    summary();
    $finish;
  end
endmodule